// File: doc/BRIEF.md
# Tagged Pointer Dereference Engine

This block resolves a tagged 32-bit term to its final value by following a chain of reference cells through a word-addressed data memory. A caller presents a term with a one-cycle start strobe. If the term is not a variable pointer, the engine finishes at once and hands the term back untouched. Otherwise it reads the cell the pointer names and repeats. It stops on the first word that is no longer a variable pointer, or on a cell that points to itself, which marks an unbound variable.

On completion the engine presents the final term, an unbound flag, one-hot type flags and an abort flag. All of them stay frozen until the next accepted start. A hop ceiling guards against corrupted cyclic chains that never reach a self-reference. Reads use a simple request/valid port with one read in flight at a time.

Top module: `ptr_chase_engine`

## Requirements
- R1: A word is a variable pointer exactly when ANDing it with 0x80000003 gives zero. A started term that fails this test finishes on the next clock edge with the result equal to the input and no memory request.
- R2: A memory request is raised only for a variable pointer, as a single-cycle pulse. Its word index is bits 31:2 of the pointer. No further request is raised until the read-valid strobe for the current one arrives.
- R3: When the word read equals the pointer used for that read, the engine stops with that word as the result and the unbound flag set.
- R4: When the word read fails the variable-pointer test (a list, a structure or a non-address), the engine stops with that word as the result and the unbound flag clear.
- R5: When the word read is a variable pointer different from the current pointer, the engine issues a new read at that word and continues.
- R6: On completion exactly one type flag is set, chosen from the result. Reference: bit 31 = 0 and bits 1:0 = 00. List: bit 31 = 0 and bits 1:0 = 10. Structure: bit 31 = 0 and bits 1:0 = 01. Constant: bit 31 = 1, or bits 1:0 = 11.
- R7: After MAX_HOPS reads without termination, the engine stops with the abort flag set and the last word read as the result. A termination under R3 or R4 on that same read takes precedence and leaves the abort flag clear.
- R8: While done is high and no new start arrives, done, the result and all flags stay unchanged. The busy output is high exactly while a chain is being followed.
- R9: A start pulse while busy is high is ignored.
- R10: A synchronous reset returns the engine to idle with done, busy and the memory request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle |
| term_i | input | 32 | Term to resolve, sampled with start_i |
| busy_o | output | 1 | Chain being followed |
| done_o | output | 1 | Result valid, held until next accepted start |
| result_o | output | 32 | Final dereferenced term |
| unbound_o | output | 1 | Chain ended on a self-referencing cell |
| abort_o | output | 1 | Hop ceiling reached |
| is_ref_o | output | 1 | Result is a reference |
| is_list_o | output | 1 | Result is a list pointer |
| is_struct_o | output | 1 | Result is a structure pointer |
| is_const_o | output | 1 | Result is a non-address value |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 30 | Word index of the read |
| mem_valid_i | input | 1 | Read data valid strobe |
| mem_rdata_i | input | 32 | Read data |

## Verification
The hop ceiling and chain termination can both fall on the same read. The bench builds two chains in its memory model whose last permitted read returns, in one case, a self-referencing cell and, in the other, a constant. Both must finish without abort: the first as unbound, the second with the constant flag. A two-cell loop that never self-references must instead abort, with the last word read as the result. The number of requests the model sees is compared with the hop count expected from the chain layout.

// File: rtl/chase_pkg.sv
package chase_pkg;
  localparam int WORD_W = 32;
  localparam int WIDX_W = WORD_W - 2;
  localparam logic [WORD_W-1:0] VARPTR_MASK = 32'h8000_0003;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_DONE = 2'd2
  } chase_state_t;

  typedef struct packed {
    logic is_ref;
    logic is_list;
    logic is_struct;
    logic is_const;
  } term_kind_t;
endpackage

// File: rtl/chase_term_class.sv
module chase_term_class
  import chase_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              is_var_o,
  output term_kind_t        kind_o
);
  always_comb begin
    is_var_o = ((word_i & VARPTR_MASK) == '0);
    kind_o   = '0;
    if (word_i[WORD_W-1]) begin
      kind_o.is_const = 1'b1;
    end else begin
      unique case (word_i[1:0])
        2'b00:   kind_o.is_ref    = 1'b1;
        2'b10:   kind_o.is_list   = 1'b1;
        2'b01:   kind_o.is_struct = 1'b1;
        default: kind_o.is_const  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/chase_hop_counter.sv
module chase_hop_counter #(
  parameter int MAX_HOPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load_one_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int CNT_W = $clog2(MAX_HOPS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_HOPS);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)             count_q <= '0;
    else if (load_one_i) count_q <= CNT_W'(1);
    else if (inc_i)      count_q <= count_q + CNT_W'(1);
  end

  assign at_limit_o = (count_q == LIMIT);

  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    count_q <= LIMIT);
  assert_no_inc_at_limit_R7: assert property (@(posedge clk) disable iff (rst)
    inc_i |-> !at_limit_o);
endmodule

// File: rtl/ptr_chase_engine.sv
module ptr_chase_engine
  import chase_pkg::*;
#(
  parameter int MAX_HOPS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] term_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o,
  output logic              unbound_o,
  output logic              abort_o,
  output logic              is_ref_o,
  output logic              is_list_o,
  output logic              is_struct_o,
  output logic              is_const_o,
  output logic              mem_req_o,
  output logic [WIDX_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  chase_state_t      state_q;
  logic [WORD_W-1:0] cur_q;
  logic [WORD_W-1:0] result_q;
  logic              unbound_q, abort_q, req_q;
  logic [WIDX_W-1:0] addr_q;
  term_kind_t        kind_q;

  logic       in_var, rd_var;
  term_kind_t in_kind, rd_kind;
  logic       hop_limit;
  logic       accept, rd_hit, rd_self, rd_follow;

  chase_term_class u_in_class (.word_i(term_i),      .is_var_o(in_var), .kind_o(in_kind));
  chase_term_class u_rd_class (.word_i(mem_rdata_i), .is_var_o(rd_var), .kind_o(rd_kind));

  assign accept    = start_i && (state_q != ST_READ);
  assign rd_hit    = (state_q == ST_READ) && mem_valid_i;
  assign rd_self   = rd_hit && (mem_rdata_i == cur_q);
  assign rd_follow = rd_hit && !rd_self && rd_var && !hop_limit;

  chase_hop_counter #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk        (clk),
    .rst        (rst),
    .load_one_i (accept && in_var),
    .inc_i      (rd_follow),
    .at_limit_o (hop_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      result_q  <= '0;
      unbound_q <= 1'b0;
      abort_q   <= 1'b0;
      kind_q    <= '0;
      req_q     <= 1'b0;
      addr_q    <= '0;
    end else begin
      req_q <= 1'b0;
      if (accept) begin
        unbound_q <= 1'b0;
        abort_q   <= 1'b0;
        if (in_var) begin
          state_q <= ST_READ;
          cur_q   <= term_i;
          req_q   <= 1'b1;
          addr_q  <= term_i[WORD_W-1:2];
        end else begin
          state_q  <= ST_DONE;
          result_q <= term_i;
          kind_q   <= in_kind;
        end
      end else if (rd_hit) begin
        if (rd_follow) begin
          cur_q  <= mem_rdata_i;
          req_q  <= 1'b1;
          addr_q <= mem_rdata_i[WORD_W-1:2];
        end else begin
          state_q   <= ST_DONE;
          result_q  <= mem_rdata_i;
          kind_q    <= rd_kind;
          unbound_q <= rd_self;
          abort_q   <= !rd_self && rd_var;
        end
      end
    end
  end

  assign busy_o      = (state_q == ST_READ);
  assign done_o      = (state_q == ST_DONE);
  assign result_o    = result_q;
  assign unbound_o   = unbound_q;
  assign abort_o     = abort_q;
  assign is_ref_o    = kind_q.is_ref;
  assign is_list_o   = kind_q.is_list;
  assign is_struct_o = kind_q.is_struct;
  assign is_const_o  = kind_q.is_const;
  assign mem_req_o   = req_q;
  assign mem_addr_o  = addr_q;

  assert_req_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);
  assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);
  assert_done_busy_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done_o && busy_o));
  assert_hold_while_done_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(result_o) && $stable(unbound_o) && $stable(abort_o)));
  assert_kind_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones({is_ref_o, is_list_o, is_struct_o, is_const_o}) == 1));
  assert_unbound_is_ref_R3: assert property (@(posedge clk) disable iff (rst)
    (done_o && unbound_o) |-> (is_ref_o && !abort_o));
  assert_abort_is_ref_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && abort_o) |-> is_ref_o);
  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !mem_valid_i) |=> busy_o);
endmodule

// File: tb/ptr_chase_engine_tb.sv
module ptr_chase_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXH = 8;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [31:0] term;
    logic [31:0] exp_res;
    logic        exp_unb;
    logic [3:0]  exp_kind;   // {ref,list,struct,const}
    logic        exp_abort;
    logic [7:0]  exp_reads;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0102, 32'h0000_0102, 1'b0, 4'b0100, 1'b0, 8'd0},
    '{32'h0000_0201, 32'h0000_0201, 1'b0, 4'b0010, 1'b0, 8'd0},
    '{32'hFF00_0000, 32'hFF00_0000, 1'b0, 4'b0001, 1'b0, 8'd0},
    '{32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0001, 1'b0, 8'd0},
    '{32'h0000_0003, 32'h0000_0003, 1'b0, 4'b0001, 1'b0, 8'd0},
    '{32'h0000_0004, 32'h0000_0004, 1'b1, 4'b1000, 1'b0, 8'd1},
    '{32'h0000_0008, 32'h0000_0004, 1'b1, 4'b1000, 1'b0, 8'd2},
    '{32'h0000_000C, 32'h0000_0102, 1'b0, 4'b0100, 1'b0, 8'd1},
    '{32'h0000_0010, 32'h0000_0201, 1'b0, 4'b0010, 1'b0, 8'd1},
    '{32'h0000_0014, 32'h8100_0007, 1'b0, 4'b0001, 1'b0, 8'd1},
    '{32'h0000_0018, 32'h0000_0102, 1'b0, 4'b0100, 1'b0, 8'd2},
    '{32'h0000_0050, 32'h8000_0001, 1'b0, 4'b0001, 1'b0, 8'd8},
    '{32'h0000_0028, 32'h0000_0028, 1'b0, 4'b1000, 1'b1, 8'd8},
    '{32'h0000_0078, 32'h0000_0094, 1'b1, 4'b1000, 1'b0, 8'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] term_i = '0;
  logic        busy_o, done_o, unbound_o, abort_o;
  logic        is_ref_o, is_list_o, is_struct_o, is_const_o;
  logic [31:0] result_o;
  logic        mem_req_o;
  logic [29:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  logic [31:0] mem_words [64];
  int          reads = 0;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_chase_engine #(.MAX_HOPS(MAXH)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .term_i(term_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .unbound_o(unbound_o), .abort_o(abort_o),
    .is_ref_o(is_ref_o), .is_list_o(is_list_o),
    .is_struct_o(is_struct_o), .is_const_o(is_const_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i)
  );

  // memory model: answers one cycle after each request pulse
  initial begin
    logic        pend;
    logic [29:0] paddr;
    pend = 1'b0;
    paddr = '0;
    forever begin
      @(negedge clk);
      mem_valid_i = 1'b0;
      if (rst) pend = 1'b0;
      else if (pend) begin
        mem_valid_i = 1'b1;
        mem_rdata_i = mem_words[paddr[5:0]];
        pend = 1'b0;
      end
      if (mem_req_o && !rst) begin
        pend  = 1'b1;
        paddr = mem_addr_o;
        reads = reads + 1;
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] t);
    @(negedge clk);
    reads   = 0;
    start_i = 1'b1;
    term_i  = t;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done_o && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) check("R8 done timeout", 32'd0, 32'd1);
  endtask

  task automatic run_vec(input vec_t v);
    pulse_start(v.term);
    wait_done();
    check("R1/R3/R4/R5/R7 result", result_o, v.exp_res);
    check("R3 unbound flag", {31'd0, unbound_o}, {31'd0, v.exp_unb});
    check("R6 type flags", {28'd0, is_ref_o, is_list_o, is_struct_o, is_const_o}, {28'd0, v.exp_kind});
    check("R7 abort flag", {31'd0, abort_o}, {31'd0, v.exp_abort});
    check("R1/R2/R5 read count", reads, {24'd0, v.exp_reads});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_words[i] = 32'h8000_0000 | i;
    mem_words[1] = 32'h0000_0004;               // self reference
    mem_words[2] = 32'h0000_0004;
    mem_words[3] = 32'h0000_0102;               // list
    mem_words[4] = 32'h0000_0201;               // structure
    mem_words[5] = 32'h8100_0007;               // constant
    mem_words[6] = 32'h0000_000C;
    mem_words[10] = 32'h0000_002C;              // two-cell loop
    mem_words[11] = 32'h0000_0028;
    for (int i = 20; i < 27; i++) mem_words[i] = (i + 1) * 4;
    mem_words[27] = 32'h8000_0001;              // constant on last permitted read
    for (int i = 30; i < 37; i++) mem_words[i] = (i + 1) * 4;
    mem_words[37] = 32'h0000_0094;              // self reference on last permitted read

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 done after reset", {31'd0, done_o}, 32'd0);
    check("R10 busy after reset", {31'd0, busy_o}, 32'd0);
    check("R10 req after reset", {31'd0, mem_req_o}, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

    // R8: outputs held while done
    repeat (6) @(negedge clk);
    check("R8 done held", {31'd0, done_o}, 32'd1);
    check("R8 result held", result_o, 32'h0000_0094);
    check("R8 unbound held", {31'd0, unbound_o}, 32'd1);

    // R8/R9: start while busy is ignored
    pulse_start(32'h0000_0050);
    check("R8 busy while following", {31'd0, busy_o}, 32'd1);
    @(negedge clk);
    start_i = 1'b1;
    term_i  = 32'h0000_0102;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check("R9 busy start ignored result", result_o, 32'h8000_0001);
    check("R9 busy start ignored reads", reads, 32'd8);

    // R10: reset in the middle of a chain
    pulse_start(32'h0000_0050);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 done after mid reset", {31'd0, done_o}, 32'd0);
    check("R10 busy after mid reset", {31'd0, busy_o}, 32'd0);
    check("R10 req after mid reset", {31'd0, mem_req_o}, 32'd0);
    rst = 1'b0;
    run_vec(VECS[9]);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule